// File: doc/BRIEF.md
# Fractional M/N Clock Divider

This block derives a slower clock, plus a matching single-cycle strobe, from a fast source clock. The ratio is not limited to integers. The average output rate is the source rate multiplied by M/N, where M and N are 20-bit unsigned values.

A phase register adds M on every source cycle and wraps modulo N. Each wrap produces one strobe. The divided clock is high for the first half of each phase period. Because of this, the output matches the requested frequency on average, and individual periods differ by at most one source cycle.

New M and N values may sit on the inputs at any time. They take effect only on the cycle the update strobe is high. A bypass select, registered on the source clock, routes the source clock itself to the clock output. A configuration that cannot be generated raises an error flag and keeps the divider outputs quiet.

Top module: `mn_clk_div`

## Requirements
- R1: After reset the tick output and the clock output are low, and the error flag is high, because the active ratio is 0/0.
- R2: `m_i` and `n_i` are copied into the active ratio only at a rising source edge where `update_i` is high. The same edge clears the phase to zero and drives tick and divided clock low. Changes to `m_i`/`n_i` without an update have no effect on the outputs.
- R3: While enabled with a valid ratio, each source edge adds M to the phase. When the sum is greater than or equal to N, N is subtracted and `tick_o` is high for the following cycle. In the N cycles after an update, exactly M ticks appear.
- R4: The spacing between consecutive ticks is always floor(N/M) or ceil(N/M) source cycles.
- R5: While running, the divided clock is high exactly when twice the phase held after the edge is below N. A rising edge of the divided clock during steady running coincides with a tick. For 2·M ≤ N this gives one clock period per tick.
- R6: While `enable_i` is low, tick and divided clock are low and the phase is zero. After re-enabling, the N cycles that follow again hold exactly M ticks.
- R7: A ratio with M = 0, N = 0, or M > N is invalid. `cfg_err_o` is high, and tick and divided clock stay low, until an update loads a valid ratio.
- R8: One source edge after `bypass_i` goes high, `clk_o` follows the source clock (high in the high phase, low in the low phase). `tick_o` is unaffected by bypass.
- R9: With M equal to N, `tick_o` is high on every running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_i | input | 1 | Route source clock to `clk_o` |
| enable_i | input | 1 | Run the divider |
| update_i | input | 1 | Load staged ratio and clear phase |
| m_i | input | 20 | Staged numerator |
| n_i | input | 20 | Staged denominator |
| clk_o | output | 1 | Divided clock, or source clock in bypass |
| tick_o | output | 1 | One-cycle strobe per output period |
| cfg_err_o | output | 1 | Active ratio is invalid |

## Verification
The bench exercises the three audio-style ratios 96/125, 6/3125 and 1536/25000, and counts ticks over one full denominator window. A divider that dropped or doubled a wrap, or compared with `>` instead of `>=`, would miss the exact count of M. Tick spacing is checked on coarse and fine ratios to catch a remainder that is lost instead of carried, which shows up as a period outside floor/ceil.

Staged inputs are changed without a strobe to expose a design that loads them continuously. The M = N case checks that the block ticks on every cycle and does not stall every second cycle. Each invalid form (zero M, zero N, M above N) must silence the outputs and raise the flag. A disable/re-enable sequence must restart from zero phase.

// File: rtl/mn_div_pkg.sv
package mn_div_pkg;
   // Operating state of the divider, shared by the staging and top logic
   typedef enum logic [1:0] {
      MN_IDLE = 2'b00,
      MN_RUN  = 2'b01,
      MN_BAD  = 2'b10
   } mn_state_e;

   localparam int unsigned MN_RATIO_W_DEF = 20;
endpackage

// File: rtl/mn_cfg_stage.sv
module mn_cfg_stage
   import mn_div_pkg::*;
#(
   parameter int unsigned RATIO_W = mn_div_pkg::MN_RATIO_W_DEF
) (
   input  logic               clk_src,
   input  logic               rst_n,
   input  logic               update_i,
   input  logic               enable_i,
   input  logic [RATIO_W-1:0] m_i,
   input  logic [RATIO_W-1:0] n_i,
   output logic [RATIO_W-1:0] m_act_o,
   output logic [RATIO_W-1:0] n_act_o,
   output mn_state_e          state_o
);
   logic [RATIO_W-1:0] m_q;
   logic [RATIO_W-1:0] n_q;
   logic               ok_q;
   logic               ok_new;

   assign ok_new = (m_i != '0) && (n_i != '0) && (m_i <= n_i);

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         m_q  <= '0;
         n_q  <= '0;
         ok_q <= 1'b0;
      end else if (update_i) begin
         m_q  <= m_i;
         n_q  <= n_i;
         ok_q <= ok_new;
      end
   end

   always_comb begin
      if (!ok_q)                      state_o = MN_BAD;
      else if (enable_i && !update_i) state_o = MN_RUN;
      else                            state_o = MN_IDLE;
   end

   assign m_act_o = m_q;
   assign n_act_o = n_q;

   // R2: without a strobe the active ratio never moves
   p_hold_ratio_r2 : assert property (@(posedge clk_src) disable iff (!rst_n)
      !update_i |=> ($stable(m_q) && $stable(n_q)));
endmodule

// File: rtl/mn_phase_acc.sv
module mn_phase_acc #(
   parameter int unsigned RATIO_W = 20
) (
   input  logic               clk_src,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               run_i,
   input  logic [RATIO_W-1:0] m_i,
   input  logic [RATIO_W-1:0] n_i,
   output logic               tick_o,
   output logic               phase_hi_o
);
   localparam int unsigned SUM_W = RATIO_W + 1;
   localparam int unsigned DBL_W = SUM_W + 1;

   logic [RATIO_W-1:0] acc_q;
   logic [SUM_W-1:0]   sum;
   logic [SUM_W-1:0]   wrapped;
   logic               wrap;
   logic [DBL_W-1:0]   dbl;
   logic               hi_d;
   logic               tick_q;
   logic               hi_q;

   always_comb begin
      sum     = {1'b0, acc_q} + {1'b0, m_i};
      wrap    = (sum >= {1'b0, n_i});
      wrapped = wrap ? (sum - {1'b0, n_i}) : sum;
      dbl     = {wrapped, 1'b0};
      hi_d    = (dbl < {2'b00, n_i});
   end

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
         hi_q   <= 1'b0;
      end else if (run_i && !clear_i) begin
         acc_q  <= wrapped[RATIO_W-1:0];
         tick_q <= wrap;
         hi_q   <= hi_d;
      end else begin
         acc_q  <= '0;
         tick_q <= 1'b0;
         hi_q   <= 1'b0;
      end
   end

   assign tick_o     = tick_q;
   assign phase_hi_o = hi_q;

   // R3: phase remains below the denominator while running
   p_no_overflow_r3 : assert property (@(posedge clk_src) disable iff (!rst_n)
      $past(run_i) |-> (acc_q < n_i));
   // R2: a strobe leaves zero phase and quiet outputs
   p_clear_r2 : assert property (@(posedge clk_src) disable iff (!rst_n)
      $past(clear_i) |-> (acc_q == '0 && !tick_q && !hi_q));
   // R9: unity ratio wraps every running cycle
   p_unity_r9 : assert property (@(posedge clk_src) disable iff (!rst_n)
      ($past(run_i) && $past(m_i == n_i)) |-> tick_q);
endmodule

// File: rtl/mn_out_sel.sv
module mn_out_sel #(
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic clk_src,
   input  logic rst_n,
   input  logic bypass_i,
   input  logic div_i,
   output logic clk_o
);
   generate
      if (BYPASS_EN) begin : g_byp
         logic sel_q;
         always_ff @(posedge clk_src or negedge rst_n) begin
            if (!rst_n) sel_q <= 1'b0;
            else        sel_q <= bypass_i;
         end
         assign clk_o = sel_q ? clk_src : div_i;
      end else begin : g_nobyp
         logic unused_byp;
         assign unused_byp = bypass_i;
         assign clk_o      = div_i;
      end
   endgenerate
endmodule

// File: rtl/mn_clk_div.sv
module mn_clk_div
   import mn_div_pkg::*;
#(
   parameter int unsigned RATIO_W   = mn_div_pkg::MN_RATIO_W_DEF,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic               clk_src,
   input  logic               rst_n,
   input  logic               bypass_i,
   input  logic               enable_i,
   input  logic               update_i,
   input  logic [RATIO_W-1:0] m_i,
   input  logic [RATIO_W-1:0] n_i,
   output logic               clk_o,
   output logic               tick_o,
   output logic               cfg_err_o
);
   generate
      if (RATIO_W < 2 || RATIO_W > 31) begin : g_bad_w
         $error("mn_clk_div: RATIO_W out of range");
      end
   endgenerate

   logic [RATIO_W-1:0] m_act;
   logic [RATIO_W-1:0] n_act;
   mn_state_e          state;
   logic               run;
   logic               div_clk;
   logic               tick;

   mn_cfg_stage #(.RATIO_W(RATIO_W)) u_cfg (
      .clk_src (clk_src),
      .rst_n   (rst_n),
      .update_i(update_i),
      .enable_i(enable_i),
      .m_i     (m_i),
      .n_i     (n_i),
      .m_act_o (m_act),
      .n_act_o (n_act),
      .state_o (state)
   );

   assign run = (state == MN_RUN);

   mn_phase_acc #(.RATIO_W(RATIO_W)) u_acc (
      .clk_src   (clk_src),
      .rst_n     (rst_n),
      .clear_i   (update_i),
      .run_i     (run),
      .m_i       (m_act),
      .n_i       (n_act),
      .tick_o    (tick),
      .phase_hi_o(div_clk)
   );

   mn_out_sel #(.BYPASS_EN(BYPASS_EN)) u_out (
      .clk_src (clk_src),
      .rst_n   (rst_n),
      .bypass_i(bypass_i),
      .div_i   (div_clk),
      .clk_o   (clk_o)
   );

   assign tick_o    = tick;
   assign cfg_err_o = (state == MN_BAD);

   // R7: an invalid ratio keeps the divider outputs quiet
   p_err_quiet_r7 : assert property (@(posedge clk_src) disable iff (!rst_n)
      cfg_err_o |-> (!tick && !div_clk));
   // R6: disabling silences the next cycle
   p_idle_r6 : assert property (@(posedge clk_src) disable iff (!rst_n)
      (!enable_i && !update_i) |=> (!tick && !div_clk));
   // R5: in steady running, a rising divided clock comes with a tick
   p_rise_tick_r5 : assert property (@(posedge clk_src) disable iff (!rst_n)
      ($rose(div_clk) && $past(run) && $past(run, 2)) |-> tick);
endmodule

// File: tb/mn_clk_div_tb_top.sv
module mn_clk_div_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 20;
   localparam int WATCHDOG   = 150000;

   logic         clk_src = 1'b0;
   logic         rst_n   = 1'b0;
   logic         bypass_i = 1'b0;
   logic         enable_i = 1'b0;
   logic         update_i = 1'b0;
   logic [W-1:0] m_i = '0;
   logic [W-1:0] n_i = '0;
   logic         clk_o, tick_o, cfg_err_o;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk_src = ~clk_src;

   mn_clk_div dut_i (
      .clk_src(clk_src), .rst_n(rst_n), .bypass_i(bypass_i),
      .enable_i(enable_i), .update_i(update_i), .m_i(m_i), .n_i(n_i),
      .clk_o(clk_o), .tick_o(tick_o), .cfg_err_o(cfg_err_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   // Behavioural reference model, updated on each rising edge
   longint mm = 0, mn = 0, macc = 0;
   bit     mval = 0, mtk = 0, mck = 0, mbyp = 0;
   always @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         mm = 0; mn = 0; macc = 0; mval = 0; mtk = 0; mck = 0; mbyp = 0;
      end else begin
         mbyp = bypass_i;
         if (update_i) begin
            mm = m_i; mn = n_i; macc = 0; mtk = 0; mck = 0;
            mval = (m_i != 0) && (n_i != 0) && (m_i <= n_i);
         end else if (enable_i && mval) begin
            macc = macc + mm;
            if (macc >= mn) begin macc = macc - mn; mtk = 1; end
            else mtk = 0;
            mck = (2 * macc < mn);
         end else begin
            macc = 0; mtk = 0; mck = 0;
         end
      end
   end

   // Per-cycle comparison and tick-spacing tracker
   bit      cmp_on = 0;
   bit      iv_on  = 0;
   int      iv_lo = 0, iv_hi = 0;
   longint  last_tick = -1;
   always @(negedge clk_src) begin
      cyc++;
      if (cmp_on) begin
         chk(tick_o == mtk, "R3 tick vs model", tick_o, mtk);
         chk(clk_o == (mbyp ? 1'b0 : mck), "R5 clk vs model", clk_o, mbyp ? 0 : mck);
         chk(cfg_err_o == !mval, "R7 err vs model", cfg_err_o, !mval);
      end
      if (iv_on && tick_o) begin
         if (last_tick >= 0)
            chk((cyc - last_tick) >= iv_lo && (cyc - last_tick) <= iv_hi,
                "R4 tick spacing", cyc - last_tick, iv_lo);
         last_tick = cyc;
      end
   end

   task automatic do_update(input int m, input int n);
      @(negedge clk_src);
      m_i = m[W-1:0]; n_i = n[W-1:0]; update_i = 1'b1;
      @(negedge clk_src);
      update_i = 1'b0;
   endtask

   task automatic count_ticks(input int ncyc, output int cnt);
      cnt = 0;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk_src);
         if (tick_o) cnt++;
      end
   endtask

   initial begin : watchdog
      while (!done && cyc < WATCHDOG) @(negedge clk_src);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      int cnt;
      repeat (3) @(negedge clk_src);
      // R1: reset state
      chk(tick_o == 0, "R1 tick", tick_o, 0);
      chk(clk_o == 0, "R1 clk", clk_o, 0);
      chk(cfg_err_o == 1, "R1 err", cfg_err_o, 1);
      rst_n = 1'b1;
      cmp_on = 1;

      // R7: enabling without a loaded ratio stays quiet
      enable_i = 1'b1;
      count_ticks(20, cnt);
      chk(cnt == 0, "R7 no ticks before update", cnt, 0);
      chk(cfg_err_o == 1, "R7 err before update", cfg_err_o, 1);

      // R3: audio ratios, exactly M ticks in N cycles
      do_update(96, 125);
      iv_on = 1; iv_lo = 1; iv_hi = 2; last_tick = -1;
      count_ticks(125, cnt);
      iv_on = 0;
      chk(cnt == 96, "R3 96/125 count", cnt, 96);
      do_update(6, 3125);
      count_ticks(3125, cnt);
      chk(cnt == 6, "R3 6/3125 count", cnt, 6);
      do_update(1536, 25000);
      iv_on = 1; iv_lo = 16; iv_hi = 17; last_tick = -1;
      count_ticks(25000, cnt);
      iv_on = 0;
      chk(cnt == 1536, "R3 1536/25000 count", cnt, 1536);

      // R4/R5: 5/17 spacing and clock shape (model compare each cycle)
      do_update(5, 17);
      iv_on = 1; iv_lo = 3; iv_hi = 4; last_tick = -1;
      count_ticks(170, cnt);
      iv_on = 0;
      chk(cnt == 50, "R4 5/17 count", cnt, 50);

      // R2: staged changes without a strobe have no effect
      do_update(5, 17);
      m_i = 20'd9; n_i = 20'd11;
      count_ticks(34, cnt);
      chk(cnt == 10, "R2 unstrobed inputs ignored", cnt, 10);

      // R6: disable then restart from zero phase
      @(negedge clk_src); enable_i = 1'b0;
      count_ticks(12, cnt);
      chk(cnt == 0, "R6 no ticks while disabled", cnt, 0);
      chk(clk_o == 0, "R6 clk low while disabled", clk_o, 0);
      enable_i = 1'b1;
      count_ticks(17, cnt);
      chk(cnt == 5, "R6 restart count", cnt, 5);

      // R7: each invalid form
      do_update(0, 10);
      count_ticks(10, cnt);
      chk(cnt == 0 && cfg_err_o == 1, "R7 zero M", cnt, 0);
      do_update(3, 0);
      count_ticks(10, cnt);
      chk(cnt == 0 && cfg_err_o == 1, "R7 zero N", cnt, 0);
      do_update(11, 10);
      count_ticks(10, cnt);
      chk(cnt == 0 && cfg_err_o == 1, "R7 M above N", cnt, 0);
      chk(clk_o == 0, "R7 clk low", clk_o, 0);

      // R9: unity ratio ticks every cycle
      do_update(7, 7);
      chk(cfg_err_o == 0, "R9 err cleared", cfg_err_o, 0);
      count_ticks(20, cnt);
      chk(cnt == 20, "R9 unity count", cnt, 20);

      // R8: bypass passes the source clock, tick unaffected
      do_update(1, 4);
      bypass_i = 1'b1;
      @(posedge clk_src); #1;
      chk(clk_o == 1, "R8 clk high phase", clk_o, 1);
      @(negedge clk_src); #1;
      chk(clk_o == 0, "R8 clk low phase", clk_o, 0);
      count_ticks(8, cnt);
      chk(cnt == 2, "R8 ticks during bypass", cnt, 2);
      bypass_i = 1'b0;
      repeat (4) @(negedge clk_src);

      cmp_on = 0;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule